// File: doc/BRIEF.md
# Edge-Selectable Peripheral Interrupt Controller

This block collects seven interrupt sources for a parallel-port peripheral and presents them to a processor as one level-sensitive request. Four of the sources are handshake input lines, two per port, which are synchronized and watched for an edge of a programmable polarity. The other three are single-cycle set strobes from two timers and a shift register, which live outside this block. Each source has a sticky flag and an enable bit. The request output is the OR of every flag that is also enabled.

The block also holds the two 8-bit port data registers and their direction registers. A write to a port data register changes only the bits whose direction bit is 1. Any access to a port data register is also the acknowledgement for that port's handshake flags. Timer and shift-register flags are acknowledged through clear strobes from those units.

The processor reaches every register through an 8-bit bus with a 3-bit register address. Reads are combinational. Their side effects, like those of writes, take effect at the next clock edge.

Top module: `edgeirq_ctl`

## Requirements
- R1: The flag order is CA2=bit0, CA1=bit1, shift register=bit2, CB2=bit3, CB1=bit4, timer 2=bit5, timer 1=bit6. `irq` is high exactly when some flag and its enable are both 1. A read of the flag register (address 5) returns the flags in bits 6..0 and the same OR condition in bit 7.
- R2: Writing the flag register clears each flag whose bit 6..0 in the written byte is 1 and leaves the other flags unchanged.
- R3: Writing the enable register (address 6) with bit 7 = 1 sets the enables marked by ones in bits 6..0. With bit 7 = 0 it clears the marked enables. A read of the enable register always returns 1 in bit 7.
- R4: The control register is at address 4. CA1 is controlled by bit 0 and CB1 by bit 4: a 1 selects the rising edge and a 0 the falling edge, and the flag is set only on the selected edge. The flag is set on the third rising clock edge after the line changes.
- R5: CA2 is controlled by field bits 3:1 and CB2 by field bits 7:5. In each field the top bit is output mode (no flag is set), the middle bit is the polarity (1 = rising edge), and the low bit is the independent bit.
- R6: A read or write of port A data (address 1) clears the CA1 flag. It also clears the CA2 flag, unless the CA2 independent bit is 1.
- R7: A read or write of port B data (address 0) clears the CB1 flag. It also clears the CB2 flag, unless the CB2 independent bit is 1.
- R8: `t1_set`, `t2_set` and `sr_set` set their flags. `t1_clr`, `t2_clr` and `sr_rd` clear them.
- R9: When a set and a clear of the same flag occur in the same cycle, the flag ends up set.
- R10: A write to a port data register replaces only the bits whose direction bit is 1 (direction B at address 2, direction A at address 3). The other bits keep their previous value.
- R11: After reset, both port data registers, the flags, the enables and the control register are 0, direction B is 0xFF and direction A is 0x00. Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; triggers read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| hs_ca1 | input | 1 | Port A handshake line 1 (asynchronous) |
| hs_ca2 | input | 1 | Port A handshake line 2 (asynchronous) |
| hs_cb1 | input | 1 | Port B handshake line 1 (asynchronous) |
| hs_cb2 | input | 1 | Port B handshake line 2 (asynchronous) |
| t1_set | input | 1 | Timer 1 expiry strobe |
| t1_clr | input | 1 | Timer 1 flag clear strobe |
| t2_set | input | 1 | Timer 2 expiry strobe |
| t2_clr | input | 1 | Timer 2 flag clear strobe |
| sr_set | input | 1 | Shift register done strobe |
| sr_rd | input | 1 | Shift register read strobe (clears its flag) |
| irq | output | 1 | Level interrupt request |
| pa_out | output | 8 | Port A data register |
| pa_dir | output | 8 | Port A direction register (1 = driven) |
| pb_out | output | 8 | Port B data register |
| pb_dir | output | 8 | Port B direction register (1 = driven) |

## Verification
The checks that clear flags assume that no set strobe or handshake edge arrives in the same cycle, so their antecedents name those inputs explicitly. The checks on port writes and register reads assume at most one bus strobe per cycle and a stable address while a strobe is high. The stimulus issues one bus operation at a time, holds the handshake lines low through reset, and leaves at least four cycles between line changes so each edge passes the synchronizer before the next operation.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;
   // register map
   localparam logic [2:0] A_PB  = 3'd0;
   localparam logic [2:0] A_PA  = 3'd1;
   localparam logic [2:0] A_DB  = 3'd2;
   localparam logic [2:0] A_DA  = 3'd3;
   localparam logic [2:0] A_CTL = 3'd4;
   localparam logic [2:0] A_FLG = 3'd5;
   localparam logic [2:0] A_ENA = 3'd6;

   localparam int NUM_FLAGS = 7;
   localparam int NUM_LINES = 4;

   // flag positions
   localparam int F_CA2 = 0;
   localparam int F_CA1 = 1;
   localparam int F_SR  = 2;
   localparam int F_CB2 = 3;
   localparam int F_CB1 = 4;
   localparam int F_T2  = 5;
   localparam int F_T1  = 6;

   // line vector order: {cb2, cb1, ca2, ca1}
   localparam int L_C1 = 0;
   localparam int L_C2 = 1;
endpackage

// File: rtl/edgeirq_sync_edge.sv
module edgeirq_sync_edge #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("edgeirq_sync_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < N; i++) begin : g_line
         logic [STAGES-1:0] chain;
         logic              last;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
               last  <= 1'b0;
            end else begin
               chain <= {chain[STAGES-2:0], din[i]};
               last  <= chain[STAGES-1];
            end
         end
         assign rise[i] = chain[STAGES-1] & ~last;
         assign fall[i] = ~chain[STAGES-1] & last;
      end
   endgenerate
endmodule

// File: rtl/edgeirq_flags.sv
module edgeirq_flags #(
   parameter int NF = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_vec,
   input  logic [NF-1:0] clr_vec,
   input  logic          en_we,
   input  logic [NF:0]   en_wdata,
   output logic [NF-1:0] flag_q,
   output logic [NF-1:0] en_q,
   output logic          irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         en_q   <= '0;
      end else begin
         // a set outranks a clear in the same cycle
         flag_q <= (flag_q & ~clr_vec) | set_vec;
         if (en_we) begin
            if (en_wdata[NF]) en_q <= en_q | en_wdata[NF-1:0];
            else              en_q <= en_q & ~en_wdata[NF-1:0];
         end
      end
   end

   assign irq = |(flag_q & en_q);
endmodule

// File: rtl/edgeirq_port.sv
module edgeirq_port #(
   parameter int          W        = 8,
   parameter logic [W-1:0] RST_DATA = '0,
   parameter logic [W-1:0] RST_DIR  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic         dir_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] data_q,
   output logic [W-1:0] dir_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= RST_DATA;
         dir_q  <= RST_DIR;
      end else begin
         if (data_we) data_q <= (data_q & ~dir_q) | (wdata & dir_q);
         if (dir_we)  dir_q  <= wdata;
      end
   end
endmodule

// File: rtl/edgeirq_ctl.sv
module edgeirq_ctl
   import edgeirq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              hs_ca1,
   input  logic              hs_ca2,
   input  logic              hs_cb1,
   input  logic              hs_cb2,
   input  logic              t1_set,
   input  logic              t1_clr,
   input  logic              t2_set,
   input  logic              t2_clr,
   input  logic              sr_set,
   input  logic              sr_rd,
   output logic              irq,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_dir,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_dir
);
   localparam int NP = NUM_LINES / 2;

   generate
      if (DATA_W != NUM_FLAGS + 1) begin : g_bad_width
         $error("edgeirq_ctl: DATA_W must equal NUM_FLAGS + 1");
      end
   endgenerate

   logic [DATA_W-1:0]    ctl_q;
   logic [NUM_LINES-1:0] lines, rise, fall, hs_set, hs_clr;
   logic [NP-1:0]        port_acc;
   logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_q, en_q;
   logic                 flg_we, edge_any;

   assign lines = {hs_cb2, hs_cb1, hs_ca2, hs_ca1};

   edgeirq_sync_edge #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(lines), .rise(rise), .fall(fall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ctl_q <= '0;
      else if (bus_wr && bus_addr == A_CTL) ctl_q <= bus_wdata;
   end

   // per-port edge selection and access clears
   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         localparam int LB = 2 * p;
         localparam int CB = 4 * p;
         localparam logic [2:0] AD = (p == 0) ? A_PA : A_PB;
         logic [2:0] fld;
         assign fld         = ctl_q[CB+3:CB+1];
         assign port_acc[p] = (bus_rd | bus_wr) && (bus_addr == AD);
         assign hs_set[LB+L_C1] = ctl_q[CB] ? rise[LB+L_C1] : fall[LB+L_C1];
         assign hs_set[LB+L_C2] = !fld[2] && (fld[1] ? rise[LB+L_C2] : fall[LB+L_C2]);
         assign hs_clr[LB+L_C1] = port_acc[p];
         assign hs_clr[LB+L_C2] = port_acc[p] && !fld[0];
      end
   endgenerate

   assign edge_any = |hs_set;
   assign flg_we   = bus_wr && (bus_addr == A_FLG);

   always_comb begin
      set_vec        = '0;
      set_vec[F_CA1] = hs_set[L_C1];
      set_vec[F_CA2] = hs_set[L_C2];
      set_vec[F_CB1] = hs_set[2 + L_C1];
      set_vec[F_CB2] = hs_set[2 + L_C2];
      set_vec[F_SR]  = sr_set;
      set_vec[F_T1]  = t1_set;
      set_vec[F_T2]  = t2_set;

      clr_vec        = flg_we ? bus_wdata[NUM_FLAGS-1:0] : '0;
      clr_vec[F_CA1] = clr_vec[F_CA1] | hs_clr[L_C1];
      clr_vec[F_CA2] = clr_vec[F_CA2] | hs_clr[L_C2];
      clr_vec[F_CB1] = clr_vec[F_CB1] | hs_clr[2 + L_C1];
      clr_vec[F_CB2] = clr_vec[F_CB2] | hs_clr[2 + L_C2];
      clr_vec[F_SR]  = clr_vec[F_SR]  | sr_rd;
      clr_vec[F_T1]  = clr_vec[F_T1]  | t1_clr;
      clr_vec[F_T2]  = clr_vec[F_T2]  | t2_clr;
   end

   edgeirq_flags #(.NF(NUM_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .en_we(bus_wr && bus_addr == A_ENA), .en_wdata(bus_wdata),
      .flag_q(flag_q), .en_q(en_q), .irq(irq)
   );

   edgeirq_port #(.W(DATA_W), .RST_DATA('0), .RST_DIR('0)) u_pa (
      .clk(clk), .rst_n(rst_n),
      .data_we(bus_wr && bus_addr == A_PA), .dir_we(bus_wr && bus_addr == A_DA),
      .wdata(bus_wdata), .data_q(pa_out), .dir_q(pa_dir)
   );

   edgeirq_port #(.W(DATA_W), .RST_DATA('0), .RST_DIR('1)) u_pb (
      .clk(clk), .rst_n(rst_n),
      .data_we(bus_wr && bus_addr == A_PB), .dir_we(bus_wr && bus_addr == A_DB),
      .wdata(bus_wdata), .data_q(pb_out), .dir_q(pb_dir)
   );

   always_comb begin
      case (bus_addr)
         A_PB:    bus_rdata = pb_out;
         A_PA:    bus_rdata = pa_out;
         A_DB:    bus_rdata = pb_dir;
         A_DA:    bus_rdata = pa_dir;
         A_CTL:   bus_rdata = ctl_q;
         A_FLG:   bus_rdata = {irq, flag_q};
         A_ENA:   bus_rdata = {1'b1, en_q};
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/edgeirq_ctl_chk.sv
module edgeirq_ctl_chk
   import edgeirq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] bus_addr,
   input logic       bus_wr,
   input logic [7:0] bus_wdata,
   input logic [7:0] bus_rdata,
   input logic       t1_set,
   input logic       t1_clr,
   input logic       t2_set,
   input logic       sr_set,
   input logic       edge_any,
   input logic       irq,
   input logic [6:0] flag_q,
   input logic [7:0] pa_out,
   input logic [7:0] pa_dir
);
   // R1
   sum_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_FLG) |-> (bus_rdata[7] == irq));

   // R2
   flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_FLG && bus_wdata[6:0] == 7'h7f &&
       !t1_set && !t2_set && !sr_set && !edge_any) |=> (flag_q == 7'h00));

   // R3
   ena_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_ENA && bus_wdata == 8'h7f) |=> !irq);

   // R3
   ena_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_ENA) |-> bus_rdata[7]);

   // R8
   t2_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t2_set |=> flag_q[F_T2]);

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_set && t1_clr) |=> flag_q[F_T1]);

   // R10
   port_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_PA) |=>
      ((pa_out & ~$past(pa_dir)) == ($past(pa_out) & ~$past(pa_dir))));
endmodule

bind edgeirq_ctl edgeirq_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .t1_set(t1_set),
   .t1_clr(t1_clr), .t2_set(t2_set), .sr_set(sr_set), .edge_any(edge_any),
   .irq(irq), .flag_q(u_flags.flag_q), .pa_out(pa_out), .pa_dir(pa_dir)
);

// File: tb/edgeirq_ctl_tb.sv
module edgeirq_ctl_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       hs_ca1 = 0, hs_ca2 = 0, hs_cb1 = 0, hs_cb2 = 0;
   logic       t1_set = 0, t1_clr = 0, t2_set = 0, t2_clr = 0, sr_set = 0, sr_rd = 0;
   logic       irq;
   logic [7:0] pa_out, pa_dir, pb_out, pb_dir;

   int vecs = 0;
   int miss = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   edgeirq_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hs_ca1(hs_ca1), .hs_ca2(hs_ca2), .hs_cb1(hs_cb1), .hs_cb2(hs_cb2),
      .t1_set(t1_set), .t1_clr(t1_clr), .t2_set(t2_set), .t2_clr(t2_clr),
      .sr_set(sr_set), .sr_rd(sr_rd), .irq(irq),
      .pa_out(pa_out), .pa_dir(pa_dir), .pb_out(pb_out), .pb_dir(pb_dir)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic s1, s2, ss, c1, c2, cs);
      @(negedge clk);
      t1_set = s1; t2_set = s2; sr_set = ss; t1_clr = c1; t2_clr = c2; sr_rd = cs;
      @(negedge clk);
      t1_set = 0; t2_set = 0; sr_set = 0; t1_clr = 0; t2_clr = 0; sr_rd = 0;
   endtask

   task automatic set_line(input int idx, input logic v);
      case (idx)
         0: hs_ca1 = v;
         1: hs_ca2 = v;
         2: hs_cb1 = v;
         default: hs_cb2 = v;
      endcase
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miss++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
      $finish;
   end

   initial begin
      logic [7:0] d, mdl, ddr, dat, exp;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R11: reset values and register map
      rd(3'd0, d); chk("R11 port B", d, 8'h00);
      rd(3'd1, d); chk("R11 port A", d, 8'h00);
      rd(3'd2, d); chk("R11 dir B", d, 8'hff);
      rd(3'd3, d); chk("R11 dir A", d, 8'h00);
      rd(3'd4, d); chk("R11 control", d, 8'h00);
      rd(3'd5, d); chk("R11 flags", d, 8'h00);
      rd(3'd6, d); chk("R3 R11 enables", d, 8'h80);
      rd(3'd7, d); chk("R11 unused", d, 8'h00);
      chk("R11 irq", {7'd0, irq}, 8'h00);

      // R10: full sweep of direction masks on both ports
      for (int p = 0; p < 2; p++) begin
         mdl = 8'h00;
         for (int m = 0; m < 256; m++) begin
            ddr = 8'(m);
            dat = 8'(m * 29 + 77);
            wr(p == 0 ? 3'd3 : 3'd2, ddr);
            wr(p == 0 ? 3'd1 : 3'd0, dat);
            mdl = (mdl & ~ddr) | (dat & ddr);
            rd(p == 0 ? 3'd1 : 3'd0, d);
            chk(p == 0 ? "R10 port A mask" : "R10 port B mask", d, mdl);
         end
      end

      // R3: enable set/clear sweep
      for (int v = 0; v < 128; v++) begin
         wr(3'd6, 8'h7f);
         wr(3'd6, 8'h80 | 8'(v));
         rd(3'd6, d); chk("R3 enable set", d, 8'h80 | 8'(v));
         wr(3'd6, 8'(v) & 8'h55);
         rd(3'd6, d); chk("R3 enable clear", d, 8'h80 | (8'(v) & 8'h2a));
      end
      wr(3'd6, 8'h7f);

      // R4 R5: edge polarity and output mode for all four lines
      for (int idx = 0; idx < 4; idx++) begin
         for (int fld = 0; fld < 8; fld++) begin
            for (int r = 0; r < 2; r++) begin
               logic [7:0] ctl;
               int bitn;
               logic hit;
               if (idx == 0 || idx == 2) begin
                  if (fld > 1) continue;
                  ctl  = (idx == 0) ? 8'(fld) : 8'(fld << 4);
                  bitn = (idx == 0) ? 1 : 4;
                  hit  = (r == fld);
               end else begin
                  ctl  = (idx == 1) ? 8'(fld << 1) : 8'(fld << 5);
                  bitn = (idx == 1) ? 0 : 3;
                  hit  = ((fld & 4) == 0) && (r == ((fld >> 1) & 1));
               end
               wr(3'd4, ctl);
               set_line(idx, r == 0);
               idle(4);
               wr(3'd5, 8'h7f);
               set_line(idx, r == 1);
               idle(4);
               rd(3'd5, d);
               exp = hit ? 8'(1 << bitn) : 8'h00;
               chk((idx == 0 || idx == 2) ? "R4 edge select" : "R5 edge select", d, exp);
               set_line(idx, 1'b0);
               idle(4);
            end
         end
      end

      // R6 R7: port access clears handshake flags
      for (int p = 0; p < 2; p++) begin
         for (int ind = 0; ind < 2; ind++) begin
            for (int acc = 0; acc < 2; acc++) begin
               logic [7:0] ctl;
               ctl = (p == 0) ? (8'h05 | (ind ? 8'h02 : 8'h00))
                              : (8'h50 | (ind ? 8'h20 : 8'h00));
               wr(3'd4, ctl);
               wr(3'd5, 8'h7f);
               if (p == 0) begin hs_ca1 = 1; hs_ca2 = 1; end
               else        begin hs_cb1 = 1; hs_cb2 = 1; end
               idle(4);
               rd(3'd5, d);
               chk(p == 0 ? "R6 flags before access" : "R7 flags before access",
                   d, p == 0 ? 8'h03 : 8'h18);
               if (acc == 0) rd(p == 0 ? 3'd1 : 3'd0, d);
               else          wr(p == 0 ? 3'd1 : 3'd0, 8'h3c);
               rd(3'd5, d);
               exp = (ind == 0) ? 8'h00 : (p == 0 ? 8'h01 : 8'h08);
               chk(p == 0 ? "R6 access clear" : "R7 access clear", d, exp);
               hs_ca1 = 0; hs_ca2 = 0; hs_cb1 = 0; hs_cb2 = 0;
               idle(4);
            end
         end
      end
      wr(3'd4, 8'h00);
      wr(3'd5, 8'h7f);

      // R8 R9: timer and shift-register strobes
      for (int k = 0; k < 3; k++) begin
         logic [7:0] b;
         b = (k == 0) ? 8'h40 : (k == 1) ? 8'h20 : 8'h04;
         pulse(k == 0, k == 1, k == 2, 0, 0, 0);
         rd(3'd5, d); chk("R8 strobe set", d, b);
         pulse(0, 0, 0, k == 0, k == 1, k == 2);
         rd(3'd5, d); chk("R8 strobe clear", d, 8'h00);
         pulse(k == 0, k == 1, k == 2, k == 0, k == 1, k == 2);
         rd(3'd5, d); chk("R9 set wins", d, b);
         wr(3'd5, 8'h7f);
      end

      // R1: request and summary bit over all enable/flag combinations
      for (int e = 0; e < 8; e++) begin
         for (int f = 0; f < 8; f++) begin
            logic [7:0] em, fm;
            logic any;
            em = ((e & 1) ? 8'h40 : 0) | ((e & 2) ? 8'h20 : 0) | ((e & 4) ? 8'h04 : 0);
            fm = ((f & 1) ? 8'h40 : 0) | ((f & 2) ? 8'h20 : 0) | ((f & 4) ? 8'h04 : 0);
            any = |(em & fm);
            wr(3'd5, 8'h7f);
            wr(3'd6, 8'h7f);
            wr(3'd6, 8'h80 | em);
            pulse(f & 1, (f >> 1) & 1, (f >> 2) & 1, 0, 0, 0);
            chk("R1 irq level", {7'd0, irq}, {7'd0, any});
            rd(3'd5, d); chk("R1 summary bit", d, fm | (any ? 8'h80 : 8'h00));
         end
      end

      // R2: partial write-one-to-clear
      wr(3'd6, 8'h7f);
      wr(3'd5, 8'h7f);
      pulse(1, 1, 1, 0, 0, 0);
      wr(3'd5, 8'h24);
      rd(3'd5, d); chk("R2 partial clear", d, 8'h40);
      wr(3'd5, 8'h00);
      rd(3'd5, d); chk("R2 zero write keeps", d, 8'h40);

      report();
      $finish;
   end
endmodule